// File: doc/BRIEF.md
# Pipeline Activity Tracker

The tracker tells a pipelined processor whether any work is still in flight. Its `idle` output can then feed clock gating or a sleep request. Two sources of activity feed one running total.

The first source is a shift window of per-cycle activity bits. A pulse marks the newest slot. Each advance strobe moves every slot one step older and discards the oldest. The window holds `MAX_LAT + 1` slots, so a pulse stays counted for exactly that many advances.

The second source is one flag per pipeline stage. A stage is marked busy or free by explicit requests. Repeated requests are filtered out, so each window slot and each stage adds at most one to the total. `idle` is high exactly when the total is zero. An internal consistency check raises `err` if the total register ever disagrees with a fresh population count of the slots and flags.

All inputs are sampled on the rising clock edge, and `count` reflects them one cycle later. When several events arrive in the same cycle, they resolve in a fixed order:

1. The advance drop.
2. The shift.
3. The pulse into the newly emptied newest slot.
4. The stage set.
5. The stage clear.

A synchronous clear overrides everything else.

Top module: `pat_tracker`

## Requirements
- R1: While `rst_n` is low, or in the cycle after `sync_clr` is sampled high (whatever the other inputs did), `count` is 0, `idle` is 1, and every window slot and stage flag is empty.
- R2: An `act_pulse` with no `advance` adds one to `count` only if the newest slot is empty. Further pulses before the next advance leave `count` unchanged.
- R3: A pulse taken into the window is removed from `count` by the (`MAX_LAT`+1)-th following `advance`, and not by any earlier one.
- R4: A `stage_set_vld` request for a stage whose flag is clear sets the flag and adds one. For a stage already set, it changes nothing.
- R5: A `stage_clr_vld` request for a set stage clears the flag and subtracts one. For a clear stage, it changes nothing.
- R6: Events in one cycle resolve in this order: the advance drop, then the shift, then the pulse into the new newest slot, then the stage set, then the stage clear. A set and a clear of the same stage therefore leave that stage clear.
- R7: `idle` is 1 exactly when `count` is 0.
- R8: `count` always equals the number of set slots plus the number of set stage flags, and `err` stays 0.
- R9: A stage index of `NUM_STAGES` or above, on either request, has no effect.
- R10: `count` never exceeds `MAX_LAT + 1 + NUM_STAGES`, and it follows the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of all state |
| act_pulse | input | 1 | Activity in this cycle |
| advance | input | 1 | Cycle-advance strobe that shifts the window |
| stage_set_vld | input | 1 | Mark a stage busy |
| stage_set_idx | input | SIW | Stage to mark busy |
| stage_clr_vld | input | 1 | Mark a stage free |
| stage_clr_idx | input | SIW | Stage to mark free |
| count | output | CW | Current activity total |
| idle | output | 1 | High when the total is zero |
| err | output | 1 | Total disagrees with the recount of the slots and flags |

## Verification
A corrupted total shows at `count`, and in `idle` when it crosses zero, on the very next cycle after the bad update. `err` also rises combinationally in that cycle. A window bit that is lost or stuck leaves the total consistent until the advance that should drop it. So such a fault surfaces at `count` up to `MAX_LAT`+1 advances late, which is why the reference comparison runs long random streams with frequent advances. A wrong stage flag shows only when a duplicate request for that stage is filtered wrongly, so the streams repeat requests on purpose.

// File: rtl/pat_pkg.sv
package pat_pkg;
  // width needed to hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // width of an index over n items
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pat_window.sv
module pat_window #(
  parameter int MAX_LAT = 4,
  localparam int W = MAX_LAT + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic         pulse,
  output logic [W-1:0] win_q,
  output logic         add_one,
  output logic         drop_one
);
  logic [W-1:0] shifted;
  logic [W-1:0] win_d;
  logic         win_en;

  generate
    if (W > 1) begin : g_deep
      assign shifted = adv ? {win_q[W-2:0], 1'b0} : win_q;
    end else begin : g_single
      assign shifted = adv ? 1'b0 : win_q;
    end
  endgenerate

  always_comb begin
    drop_one = adv & win_q[W-1];
    add_one  = pulse & ~shifted[0];
    win_en   = clr | adv | pulse;
    win_d    = shifted;
    win_d[0] = shifted[0] | pulse;
    if (clr) win_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_d;
  end
endmodule

// File: rtl/pat_stage_flags.sv
module pat_stage_flags #(
  parameter int NUM_STAGES = 5,
  localparam int SIW = pat_pkg::idx_width(NUM_STAGES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  set_vld,
  input  logic [SIW-1:0]        set_idx,
  input  logic                  clr_vld,
  input  logic [SIW-1:0]        clr_idx,
  output logic [NUM_STAGES-1:0] flag_q,
  output logic                  add_one,
  output logic                  drop_one
);
  logic [NUM_STAGES-1:0] set_hit;
  logic [NUM_STAGES-1:0] clr_hit;
  logic [NUM_STAGES-1:0] mid;
  logic [NUM_STAGES-1:0] flag_d;
  logic                  flag_en;

  // decoders; indices past the last stage match nothing
  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_dec
    assign set_hit[i] = set_vld & (set_idx == SIW'(i));
    assign clr_hit[i] = clr_vld & (clr_idx == SIW'(i));
  end

  always_comb begin
    add_one  = |(set_hit & ~flag_q);
    mid      = flag_q | set_hit;
    drop_one = |(clr_hit & mid);
    flag_d   = clr ? '0 : (mid & ~clr_hit);
    flag_en  = clr | set_vld | clr_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end
endmodule

// File: rtl/pat_counter.sv
module pat_counter #(
  parameter int NUM_STAGES = 5,
  parameter int MAX_LAT = 4,
  localparam int W = MAX_LAT + 1,
  localparam int CW = pat_pkg::cnt_width(W + NUM_STAGES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  win_add,
  input  logic                  win_drop,
  input  logic                  stg_add,
  input  logic                  stg_drop,
  input  logic [W-1:0]          win_q,
  input  logic [NUM_STAGES-1:0] flag_q,
  output logic [CW-1:0]         cnt_q,
  output logic                  mismatch
);
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] recount;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | win_add | win_drop | stg_add | stg_drop;
    cnt_d  = cnt_q + CW'(win_add) + CW'(stg_add) - CW'(win_drop) - CW'(stg_drop);
    if (clr) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // independent recount of the state bits
  always_comb begin
    recount = '0;
    for (int i = 0; i < W; i++)          recount = recount + CW'(win_q[i]);
    for (int j = 0; j < NUM_STAGES; j++) recount = recount + CW'(flag_q[j]);
    mismatch = (recount != cnt_q);
  end
endmodule

// File: rtl/pat_tracker.sv
module pat_tracker #(
  parameter int NUM_STAGES = 5,
  parameter int MAX_LAT = 4,
  localparam int SIW = pat_pkg::idx_width(NUM_STAGES),
  localparam int CW = pat_pkg::cnt_width(MAX_LAT + 1 + NUM_STAGES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sync_clr,
  input  logic           act_pulse,
  input  logic           advance,
  input  logic           stage_set_vld,
  input  logic [SIW-1:0] stage_set_idx,
  input  logic           stage_clr_vld,
  input  logic [SIW-1:0] stage_clr_idx,
  output logic [CW-1:0]  count,
  output logic           idle,
  output logic           err
);
  localparam int W = MAX_LAT + 1;

  logic [W-1:0]          win_q;
  logic [NUM_STAGES-1:0] flag_q;
  logic                  win_add, win_drop, stg_add, stg_drop;

  pat_window #(.MAX_LAT(MAX_LAT)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(sync_clr), .adv(advance), .pulse(act_pulse),
    .win_q(win_q), .add_one(win_add), .drop_one(win_drop)
  );

  pat_stage_flags #(.NUM_STAGES(NUM_STAGES)) u_stg (
    .clk(clk), .rst_n(rst_n), .clr(sync_clr),
    .set_vld(stage_set_vld), .set_idx(stage_set_idx),
    .clr_vld(stage_clr_vld), .clr_idx(stage_clr_idx),
    .flag_q(flag_q), .add_one(stg_add), .drop_one(stg_drop)
  );

  pat_counter #(.NUM_STAGES(NUM_STAGES), .MAX_LAT(MAX_LAT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(sync_clr),
    .win_add(win_add), .win_drop(win_drop), .stg_add(stg_add), .stg_drop(stg_drop),
    .win_q(win_q), .flag_q(flag_q), .cnt_q(count), .mismatch(err)
  );

  assign idle = (count == '0);
endmodule

// File: rtl/pat_tracker_chk.sv
module pat_tracker_chk #(
  parameter int NUM_STAGES = 5,
  parameter int MAX_LAT = 4,
  localparam int SIW = pat_pkg::idx_width(NUM_STAGES),
  localparam int CW = pat_pkg::cnt_width(MAX_LAT + 1 + NUM_STAGES)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sync_clr,
  input logic                  act_pulse,
  input logic                  advance,
  input logic                  stage_set_vld,
  input logic [SIW-1:0]        stage_set_idx,
  input logic                  stage_clr_vld,
  input logic [CW-1:0]         count,
  input logic                  idle,
  input logic                  err,
  input logic [MAX_LAT:0]      win_q,
  input logic [NUM_STAGES-1:0] flag_q
);
  localparam int MAXC = MAX_LAT + 1 + NUM_STAGES;

  logic quiet_stage;
  assign quiet_stage = !stage_set_vld && !stage_clr_vld && !sync_clr;

  // R8: total matches the state bits it summarises
  a_r8_count_sum: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) == $countones(win_q) + $countones(flag_q));

  a_r8_no_err: assert property (@(posedge clk) disable iff (!rst_n) !err);

  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (idle && win_q == '0 && flag_q == '0));

  a_r2_dup_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pulse && !advance && win_q[0] && quiet_stage) |=> $stable(count));

  a_r3_oldest_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && win_q[MAX_LAT] && !act_pulse && quiet_stage)
      |=> (count == $past(count) - 1'b1));

  a_r4_dup_set: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_set_vld && int'(stage_set_idx) < NUM_STAGES && flag_q[stage_set_idx]
     && !stage_clr_vld && !sync_clr && !act_pulse && !advance) |=> $stable(count));

  a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= MAXC);
endmodule

bind pat_tracker pat_tracker_chk #(.NUM_STAGES(NUM_STAGES), .MAX_LAT(MAX_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .act_pulse(act_pulse),
  .advance(advance), .stage_set_vld(stage_set_vld), .stage_set_idx(stage_set_idx),
  .stage_clr_vld(stage_clr_vld), .count(count), .idle(idle), .err(err),
  .win_q(win_q), .flag_q(flag_q)
);

// File: tb/pat_tracker_test.sv
`timescale 1ns/1ps
module pat_tracker_test;
  localparam int NS  = 5;
  localparam int LAT = 4;
  localparam int W   = LAT + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_clr = 1'b0, act_pulse = 1'b0, advance = 1'b0;
  logic       stage_set_vld = 1'b0, stage_clr_vld = 1'b0;
  logic [2:0] stage_set_idx = '0, stage_clr_idx = '0;
  logic [3:0] count;
  logic       idle, err;

  int tests = 0, fails = 0;
  bit mw[W];
  bit mf[NS];
  int mc = 0;

  always #4 clk = ~clk;

  pat_tracker #(.NUM_STAGES(NS), .MAX_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .act_pulse(act_pulse),
    .advance(advance), .stage_set_vld(stage_set_vld), .stage_set_idx(stage_set_idx),
    .stage_clr_vld(stage_clr_vld), .stage_clr_idx(stage_clr_idx),
    .count(count), .idle(idle), .err(err)
  );

  task automatic model_clear();
    for (int i = 0; i < W; i++) mw[i] = 1'b0;
    for (int i = 0; i < NS; i++) mf[i] = 1'b0;
    mc = 0;
  endtask

  // reference: advance drop, shift, pulse, set, clear
  task automatic model_step(input bit c, p, a, sv, input int si, input bit cv, input int ci);
    if (c) begin model_clear(); return; end
    if (a) begin
      if (mw[W-1]) mc--;
      for (int i = W-1; i > 0; i--) mw[i] = mw[i-1];
      mw[0] = 1'b0;
    end
    if (p && !mw[0]) begin mw[0] = 1'b1; mc++; end
    if (sv && si < NS && !mf[si]) begin mf[si] = 1'b1; mc++; end
    if (cv && ci < NS && mf[ci])  begin mf[ci] = 1'b0; mc--; end
  endtask

  task automatic check(input string tag);
    tests++;
    if (int'(count) != mc) begin
      fails++;
      $display("FAIL %s count: actual %0d expected %0d", tag, count, mc);
    end
    tests++;
    if (idle != (mc == 0)) begin
      fails++;
      $display("FAIL R7 idle: actual %0b expected %0b", idle, (mc == 0));
    end
    tests++;
    if (err !== 1'b0) begin
      fails++;
      $display("FAIL R8 err: actual %0b expected 0", err);
    end
  endtask

  task automatic step(input bit c, p, a, sv, input int si, input bit cv, input int ci,
                      input string tag);
    sync_clr = c; act_pulse = p; advance = a;
    stage_set_vld = sv; stage_set_idx = 3'(si);
    stage_clr_vld = cv; stage_clr_idx = 3'(ci);
    model_step(c, p, a, sv, si, cv, ci);
    @(negedge clk);
    check(tag);
  endtask

  initial begin : watchdog
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R2: first pulse counts, repeats do not
    step(0,1,0,0,0,0,0,"R2");
    step(0,1,0,0,0,0,0,"R2");
    step(0,1,0,0,0,0,0,"R2");
    // R3: kept for LAT advances, dropped on the next
    for (int k = 0; k < LAT; k++) step(0,0,1,0,0,0,0,"R3");
    step(0,0,1,0,0,0,0,"R3");
    // R4 and R5: duplicates filtered
    step(0,0,0,1,2,0,0,"R4");
    step(0,0,0,1,2,0,0,"R4");
    step(0,0,0,0,0,1,3,"R5");
    step(0,0,0,0,0,1,2,"R5");
    step(0,0,0,0,0,1,2,"R5");
    // R6: drop, shift and pulse in one cycle; set and clear of one stage
    step(0,1,0,0,0,0,0,"R6");
    for (int k = 0; k < LAT; k++) step(0,0,1,0,0,0,0,"R6");
    step(0,1,1,1,1,1,1,"R6");
    step(0,0,0,1,4,0,0,"R6");
    step(0,0,0,1,4,1,4,"R6");
    // R9: indices past the last stage ignored
    step(0,0,0,1,6,0,0,"R9");
    step(0,0,0,1,7,0,0,"R9");
    step(0,0,0,1,0,0,0,"R9");
    step(0,0,0,0,0,1,5,"R9");
    // R10: fill to the maximum
    for (int k = 0; k < NS; k++) step(0,1,1,1,k,0,0,"R10");
    step(0,1,0,0,0,0,0,"R10");
    // R1: synchronous clear wins over everything else
    step(1,1,1,1,3,1,0,"R1");
    step(0,0,0,0,0,0,0,"R1");

    // random streams against the model, including duplicate requests
    for (int n = 0; n < 4000; n++) begin
      step(($urandom_range(0, 199) == 0), ($urandom_range(0, 2) == 0),
           ($urandom_range(0, 1) == 0), ($urandom_range(0, 3) == 0),
           $urandom_range(0, 7), ($urandom_range(0, 3) == 0),
           $urandom_range(0, 7), "R10");
    end

    sync_clr = 1'b0; act_pulse = 1'b0; advance = 1'b0;
    stage_set_vld = 1'b0; stage_clr_vld = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule